// File: doc/BRIEF.md
# I2C EEPROM slave front end

This block is the bus-facing controller of a 256-byte serial memory that answers on a two-wire I2C bus. It oversamples SCL and SDA on the system clock, detects START and STOP, receives the control byte and checks it against three chip-select straps. It acknowledges accepted bytes by pulling SDA low through an open-drain enable, and it loads an 8-bit word pointer. Downstream logic receives single-cycle strobes for each written byte, for a STOP that closes a write, and for the one-time command that sets the software write-protect register.

Two device codes are recognised. The memory code serves reads and writes. A second code, valid only with the direction bit low, carries the write-protect command. Reads shift out a byte that the memory supplies for the current pointer, and the pointer then advances. While the downstream engine reports an internal write in progress, the block acknowledges nothing and so stays silent on the bus.

Top module: `eeprom_i2c_front`

## Requirements
- R1: A control byte with bits [7:4] = 1010 and bits [3:1] equal to `chip_sel` is acknowledged; bit 0 = 1 selects read (`rd_mode` high), 0 selects write.
- R2: A control byte with bits [7:4] = 0110, matching select bits and bit 0 = 0 is acknowledged, and `wp_set_stb` pulses for one cycle when that acknowledge ends; the same code with bit 0 = 1 is not acknowledged.
- R3: A control byte with any other code or with select bits that differ from `chip_sel` is not acknowledged, and SDA stays released for the rest of that transfer until the next START.
- R4: The acknowledge drives SDA low from the SCL fall after the eighth bit to the SCL fall that ends the ninth clock, and releases it afterwards.
- R5: In a write, the byte after the control byte is loaded into `cur_addr`.
- R6: Each further write byte pulses `wr_stb` once with `wr_addr` = pointer and `wr_byte` = the byte. The pointer then advances in its low four bits only, so the upper four bits stay fixed and the address rolls over within a 16-byte page.
- R7: In a read, `rd_byte` is shifted out MSB first, with SDA changing only while SCL is low. `cur_addr` increments after each byte and wraps from FFh to 00h.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R9: While `wr_busy` is high, no byte of any kind is acknowledged and no `wr_stb` is issued.
- R10: A STOP (SDA rising with SCL high) releases SDA. `stop_stb` pulses once if a write-direction control byte was accepted since the last START.
- R11: A START (SDA falling with SCL high) restarts control-byte reception at any point, so a write of the word address followed by a repeated START and a read control byte reads from that address.
- R12: After reset SDA is released, `cur_addr` is 00h and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| chip_sel | input | 3 | Chip-select strap values |
| wr_busy | input | 1 | Internal write in progress; suppresses acknowledges |
| rd_byte | input | 8 | Memory byte at `cur_addr` |
| cur_addr | output | 8 | Word address pointer |
| wr_stb | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 8 | Address for the byte in `wr_byte` |
| wr_byte | output | 8 | Received write data |
| stop_stb | output | 1 | STOP closing an accepted write transfer |
| rd_mode | output | 1 | Direction of the accepted control byte, 1 = read |
| wp_set_stb | output | 1 | Write-protect set command accepted |

## Verification
On every cycle the assertions check that an acknowledge never begins while `wr_busy` was high, that a STOP leaves SDA released, that the strobes are single pulses and never coincide, and that SDA moves only while SCL is low except at START or STOP. Whether a control byte is accepted, the page rollover of write addresses, the order and wrap of read data, the random-read sequence and the silence after a master NACK depend on whole bus transfers. Only the bench's scenarios can show these.

// File: rtl/eif_pkg.sv
package eif_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } eif_state_e;

  typedef enum logic [1:0] {
    RL_CTRL,
    RL_ADDR,
    RL_DATA
  } eif_role_e;

  localparam logic [3:0] MEM_CODE = 4'b1010;
  localparam logic [3:0] WPR_CODE = 4'b0110;
endpackage

// File: rtl/eif_line_sync.sv
module eif_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eif_addr_ptr.sv
module eif_addr_ptr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_seq,
  input  logic              inc_page,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_d;
  logic [ADDR_W-1:0] page_next;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      assign page_next = ptr + 1'b1;
    end else begin : g_paged
      logic [PAGE_W-1:0] low_next;
      assign low_next  = ptr[PAGE_W-1:0] + 1'b1;
      assign page_next = {ptr[ADDR_W-1:PAGE_W], low_next};
    end
  endgenerate

  always_comb begin
    ptr_d = ptr;
    if (load)          ptr_d = load_val;
    else if (inc_seq)  ptr_d = ptr + 1'b1;
    else if (inc_page) ptr_d = page_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end
endmodule

// File: rtl/eif_shift.sv
module eif_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              sda_s,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_val,
  input  logic              tx_shift,
  output logic [DATA_W-1:0] rx_byte,
  output logic              tx_bit
);
  logic [DATA_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      tx_q    <= '1;
    end else begin
      if (rx_en)         rx_byte <= {rx_byte[DATA_W-2:0], sda_s};
      if (tx_load)       tx_q    <= tx_val;
      else if (tx_shift) tx_q    <= {tx_q[DATA_W-2:0], 1'b1};
    end
  end

  assign tx_bit = tx_q[DATA_W-1];
endmodule

// File: rtl/eif_ctrl.sv
module eif_ctrl
  import eif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int CS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_bit,
  input  logic [CS_W-1:0]   chip_sel,
  input  logic              wr_busy,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              rx_en,
  output logic              tx_load,
  output logic              tx_shift,
  output logic              ptr_load,
  output logic              ptr_inc_seq,
  output logic              ptr_inc_page,
  output logic              ack_phase,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_byte,
  output logic              stop_stb,
  output logic              rd_mode,
  output logic              wp_set_stb
);
  localparam int          CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(DATA_W - 1);

  eif_state_e       state_q, state_d;
  eif_role_e        role_q, role_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             rd_q, rd_d;
  logic             wpc_q, wpc_d;
  logic             wsel_q, wsel_d;
  logic             mack_q, mack_d;
  logic             wr_stb_d, stop_stb_d, wp_stb_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [DATA_W-1:0] wr_byte_d;

  logic [3:0]      code_f;
  logic [CS_W-1:0] cs_f;
  logic            dir_f;
  logic            mem_hit, wpc_hit;

  assign code_f  = rx_byte[DATA_W-1 -: 4];
  assign cs_f    = rx_byte[CS_W:1];
  assign dir_f   = rx_byte[0];
  assign mem_hit = (code_f == MEM_CODE) && (cs_f == chip_sel);
  assign wpc_hit = (code_f == WPR_CODE) && (cs_f == chip_sel) && !dir_f;

  always_comb begin
    state_d      = state_q;
    role_d       = role_q;
    bit_d        = bit_q;
    rd_d         = rd_q;
    wpc_d        = wpc_q;
    wsel_d       = wsel_q;
    mack_d       = mack_q;
    wr_stb_d     = 1'b0;
    stop_stb_d   = 1'b0;
    wp_stb_d     = 1'b0;
    wr_addr_d    = wr_addr;
    wr_byte_d    = wr_byte;
    rx_en        = 1'b0;
    tx_load      = 1'b0;
    tx_shift     = 1'b0;
    ptr_load     = 1'b0;
    ptr_inc_seq  = 1'b0;
    ptr_inc_page = 1'b0;

    if (stop_det) begin
      state_d    = ST_IDLE;
      stop_stb_d = wsel_q;
      wsel_d     = 1'b0;
      wpc_d      = 1'b0;
    end else if (start_det) begin
      state_d = ST_RX;
      role_d  = RL_CTRL;
      bit_d   = '0;
      wsel_d  = 1'b0;
      wpc_d   = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && (bit_q != BYTE_END)) begin
            rx_en = 1'b1;
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && (bit_q == BYTE_END)) begin
            if (wr_busy) begin
              state_d = ST_IDLE;
            end else begin
              case (role_q)
                RL_CTRL: begin
                  if (mem_hit || wpc_hit) begin
                    state_d = ST_ACK;
                    rd_d    = mem_hit & dir_f;
                    wpc_d   = wpc_hit;
                    wsel_d  = ~dir_f;
                  end else begin
                    state_d = ST_IDLE;
                  end
                end
                RL_ADDR: begin
                  ptr_load = 1'b1;
                  state_d  = ST_ACK;
                end
                default: begin
                  wr_stb_d     = 1'b1;
                  wr_addr_d    = cur_addr;
                  wr_byte_d    = rx_byte;
                  ptr_inc_page = 1'b1;
                  state_d      = ST_ACK;
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (wpc_q) begin
              wp_stb_d = 1'b1;
              wpc_d    = 1'b0;
              state_d  = ST_IDLE;
            end else if (rd_q) begin
              tx_load = 1'b1;
              state_d = ST_TX;
            end else begin
              state_d = ST_RX;
              role_d  = (role_q == RL_CTRL) ? RL_ADDR : RL_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == LAST_TX) begin
              ptr_inc_seq = 1'b1;
              mack_d      = 1'b0;
              state_d     = ST_MACK;
            end else begin
              tx_shift = 1'b1;
              bit_d    = bit_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_s) state_d = ST_IDLE;
            else       mack_d  = 1'b1;
          end else if (scl_fall && mack_q) begin
            tx_load = 1'b1;
            bit_d   = '0;
            state_d = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      role_q     <= RL_CTRL;
      bit_q      <= '0;
      rd_q       <= 1'b0;
      wpc_q      <= 1'b0;
      wsel_q     <= 1'b0;
      mack_q     <= 1'b0;
      wr_stb     <= 1'b0;
      stop_stb   <= 1'b0;
      wp_set_stb <= 1'b0;
      wr_addr    <= '0;
      wr_byte    <= '0;
    end else begin
      state_q    <= state_d;
      role_q     <= role_d;
      bit_q      <= bit_d;
      rd_q       <= rd_d;
      wpc_q      <= wpc_d;
      wsel_q     <= wsel_d;
      mack_q     <= mack_d;
      wr_stb     <= wr_stb_d;
      stop_stb   <= stop_stb_d;
      wp_set_stb <= wp_stb_d;
      wr_addr    <= wr_addr_d;
      wr_byte    <= wr_byte_d;
    end
  end

  assign ack_phase = (state_q == ST_ACK);
  assign sda_oe    = ack_phase | ((state_q == ST_TX) & ~tx_bit);
  assign rd_mode   = rd_q;
endmodule

// File: rtl/eeprom_i2c_front.sv
module eeprom_i2c_front #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int CS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [CS_W-1:0]   chip_sel,
  input  logic              wr_busy,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_byte,
  output logic              stop_stb,
  output logic              rd_mode,
  output logic              wp_set_stb
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic rx_en, tx_load, tx_shift, tx_bit;
  logic ptr_load, ptr_inc_seq, ptr_inc_page, ack_phase;
  logic [DATA_W-1:0] rx_byte;

  eif_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eif_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sda_s(sda_s),
    .tx_load(tx_load), .tx_val(rd_byte), .tx_shift(tx_shift),
    .rx_byte(rx_byte), .tx_bit(tx_bit)
  );

  eif_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(rx_byte[ADDR_W-1:0]),
    .inc_seq(ptr_inc_seq), .inc_page(ptr_inc_page), .ptr(cur_addr)
  );

  eif_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CS_W(CS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .rx_byte(rx_byte), .tx_bit(tx_bit), .chip_sel(chip_sel), .wr_busy(wr_busy),
    .cur_addr(cur_addr), .rx_en(rx_en), .tx_load(tx_load), .tx_shift(tx_shift),
    .ptr_load(ptr_load), .ptr_inc_seq(ptr_inc_seq), .ptr_inc_page(ptr_inc_page),
    .ack_phase(ack_phase), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_byte(wr_byte), .stop_stb(stop_stb), .rd_mode(rd_mode),
    .wp_set_stb(wp_set_stb)
  );
endmodule

// File: rtl/eif_chk.sv
module eif_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic ack_phase,
  input logic wr_busy,
  input logic wr_stb,
  input logic wp_set_stb,
  input logic stop_stb
);
  AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_phase) |-> !$past(wr_busy)); // R9

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe); // R10

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, wp_set_stb, stop_stb})); // R6

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R6

  AST_WP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wp_set_stb |=> !wp_set_stb); // R2

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(stop_det) && !$past(start_det)) |-> !$past(scl_s)); // R7
endmodule

bind eeprom_i2c_front eif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .ack_phase(ack_phase),
  .wr_busy(wr_busy), .wr_stb(wr_stb), .wp_set_stb(wp_set_stb),
  .stop_stb(stop_stb)
);

// File: tb/sim_eeprom_i2c_front.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_front;
  localparam int HB = 10;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] C_WR  = 8'hAA;
  localparam logic [7:0] C_RD  = 8'hAB;
  localparam logic [7:0] C_WP  = 8'h6A;
  localparam logic [7:0] C_WPR = 8'h6B;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m, wr_busy;
  logic sda_oe, wr_stb, stop_stb, rd_mode, wp_set_stb;
  logic [7:0] rd_byte, cur_addr, wr_addr, wr_byte;
  logic [7:0] mem [256];
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  int n_wr = 0, n_stop = 0, n_wp = 0;
  logic [7:0] log_a [16];
  logic [7:0] log_d [16];

  always #4 clk = ~clk;

  eeprom_i2c_front u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .chip_sel(CS), .wr_busy(wr_busy), .rd_byte(rd_byte), .cur_addr(cur_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_byte(wr_byte), .stop_stb(stop_stb),
    .rd_mode(rd_mode), .wp_set_stb(wp_set_stb)
  );

  assign rd_byte = mem[cur_addr];

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        log_a[n_wr & 15] = wr_addr;
        log_d[n_wr & 15] = wr_byte;
        mem[wr_addr] = wr_byte;
        n_wr++;
      end
      if (stop_stb)   n_stop++;
      if (wp_set_stb) n_wp++;
    end
  end

  function automatic logic [7:0] init_val(input logic [7:0] a);
    return a ^ 8'h5C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HB) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half();
      scl_m = 1'b1; half();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; half();
    scl_m = 1'b1;
    repeat (HB/2) @(negedge clk);
    ack = ~sda_line;
    repeat (HB/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      half();
      scl_m = 1'b1;
      repeat (HB/2) @(negedge clk);
      b = {b[6:0], sda_line};
      repeat (HB/2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = ~mack; half();
    scl_m = 1'b1; half();
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk("R12 sda_oe after reset", sda_oe, 0);
    chk("R12 cur_addr after reset", cur_addr, 8'h00);
    chk("R12 strobes after reset", {wr_stb, stop_stb, wp_set_stb}, 0);
  endtask

  task automatic t_byte_write();
    logic ack;
    int w0, s0;
    w0 = n_wr; s0 = n_stop;
    i2c_start();
    send_byte(C_WR, ack);
    chk("R1 write control acked", ack, 1);
    chk("R1 rd_mode low for write", rd_mode, 0);
    repeat (6) @(negedge clk);
    chk("R4 ack released after ninth clock", sda_oe, 0);
    send_byte(8'h35, ack);
    chk("R5 word address acked", ack, 1);
    repeat (6) @(negedge clk);
    chk("R5 pointer loaded", cur_addr, 8'h35);
    send_byte(8'h5A, ack);
    repeat (6) @(negedge clk);
    chk("R6 data acked", ack, 1);
    chk("R6 one write strobe", n_wr - w0, 1);
    chk("R6 write address", log_a[w0 & 15], 8'h35);
    chk("R6 write data", log_d[w0 & 15], 8'h5A);
    i2c_stop();
    chk("R10 stop strobe after write", n_stop - s0, 1);
    chk("R10 sda released after stop", sda_oe, 0);
  endtask

  task automatic t_page_roll();
    logic ack;
    int w0;
    w0 = n_wr;
    i2c_start();
    send_byte(C_WR, ack);
    send_byte(8'h2E, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    send_byte(8'h33, ack);
    repeat (6) @(negedge clk);
    chk("R6 page write count", n_wr - w0, 3);
    chk("R6 first page address", log_a[w0 & 15], 8'h2E);
    chk("R6 second page address", log_a[(w0 + 1) & 15], 8'h2F);
    chk("R6 rollover keeps upper bits", log_a[(w0 + 2) & 15], 8'h20);
    i2c_stop();
  endtask

  task automatic t_random_read();
    logic ack;
    logic [7:0] b;
    int s0;
    s0 = n_stop;
    i2c_start();
    send_byte(C_WR, ack);
    send_byte(8'hFE, ack);
    i2c_start();
    send_byte(C_RD, ack);
    chk("R11 read control acked after repeated start", ack, 1);
    chk("R1 rd_mode high for read", rd_mode, 1);
    recv_byte(1'b1, b);
    chk("R7 read byte at FEh", b, init_val(8'hFE));
    recv_byte(1'b1, b);
    chk("R7 read byte at FFh", b, init_val(8'hFF));
    recv_byte(1'b0, b);
    chk("R7 read wraps to 00h", b, init_val(8'h00));
    chk("R7 pointer after wrap", cur_addr, 8'h01);
    recv_byte(1'b0, b);
    chk("R8 silent after master NACK", b, 8'hFF);
    i2c_stop();
    chk("R10 no stop strobe for read transfer", n_stop - s0, 0);
  endtask

  task automatic t_readback();
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte(C_WR, ack);
    send_byte(8'h2F, ack);
    i2c_start();
    send_byte(C_RD, ack);
    recv_byte(1'b1, b);
    chk("R7 read back written byte", b, 8'h22);
    recv_byte(1'b0, b);
    chk("R7 sequential read next address", b, init_val(8'h30));
    i2c_stop();
  endtask

  task automatic t_bad_select();
    logic ack;
    i2c_start();
    send_byte(8'hA4, ack);
    chk("R3 wrong chip select not acked", ack, 0);
    send_byte(8'h00, ack);
    chk("R3 stays silent for rest of transfer", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'hBA, ack);
    chk("R3 foreign device code not acked", ack, 0);
    i2c_stop();
  endtask

  task automatic t_wp_cmd();
    logic ack;
    int p0;
    p0 = n_wp;
    i2c_start();
    send_byte(C_WP, ack);
    repeat (6) @(negedge clk);
    chk("R2 protect command acked", ack, 1);
    chk("R2 protect strobe once", n_wp - p0, 1);
    i2c_stop();
    i2c_start();
    send_byte(C_WPR, ack);
    chk("R2 protect code with read bit not acked", ack, 0);
    i2c_stop();
    chk("R2 no extra protect strobe", n_wp - p0, 1);
  endtask

  task automatic t_busy();
    logic ack;
    int w0;
    w0 = n_wr;
    wr_busy = 1'b1;
    i2c_start();
    send_byte(C_WR, ack);
    chk("R9 control not acked while busy", ack, 0);
    i2c_stop();
    wr_busy = 1'b0;
    i2c_start();
    send_byte(C_WR, ack);
    send_byte(8'h40, ack);
    wr_busy = 1'b1;
    send_byte(8'h99, ack);
    repeat (6) @(negedge clk);
    chk("R9 data not acked while busy", ack, 0);
    chk("R9 no write strobe while busy", n_wr - w0, 0);
    wr_busy = 1'b0;
    i2c_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(8'(i));
    scl_m = 1'b1; sda_m = 1'b1; wr_busy = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_byte_write();
    t_page_roll();
    t_random_read();
    t_readback();
    t_bad_select();
    t_wp_cmd();
    t_busy();
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule